// File: doc/BRIEF.md
# Conversion Result Register with Active-Low Ready

This block holds the latest 24-bit conversion result of a converter front end. A host reads it either as three bytes through a byte-select port or as one parallel word. Raw results from the digital filter arrive on a one-cycle strobe. Each result is formatted as it is captured:

- as two's complement or as offset binary;
- optionally clamped so that no negative value is reported.

The block then loads the result into the output register and signals it to the host with an active-low ready flag.

The ready flag rises before every load and falls once the new word is in place. While the host is reading, no new word may disturb the register. A result that arrives during a read is parked, and it is loaded once the host signals the end of its read. A result the host never reads is replaced by the next one.

After the input multiplexer switches channel, the filter still carries data from the old channel. For that reason a separate valid output marks the next three loads as invalid, while the ready flag keeps toggling as usual.

Top module: `conv_result_reg`

## Requirements
- R1: After reset, readyN is 1, dataValid is 0 and dataOut is zero.
- R2: With no read in progress, a resultValid pulse sets readyN to 1 at the following clock edge. At the edge after that, the formatted result appears on dataOut and readyN goes to 0. dataOut never changes at an edge that leaves readyN at 1.
- R3: A read is in progress from the edge that samples readStart until the edge that samples readEnd. During a read, a result strobe leaves readyN low and dataOut unchanged. The last result received during the read is loaded one edge after readEnd, and readyN falls at that edge.
- R4: readEnd sets readyN to 1 at the edge that samples it.
- R5: A loaded result that is not read is overwritten by the next result.
- R6: With fmtOffset = 0 the output is the raw two's complement value. With fmtOffset = 1 the output equals the raw value with bit 23 inverted (offset binary). The format bits are sampled in the cycle of the strobe.
- R7: With unipolarEn = 1, a result with bit 23 set is clamped to zero before formatting. The output is then 0x000000 in two's complement or 0x800000 in offset binary. Non-negative results pass unchanged.
- R8: After a chanSwitch pulse, the next three loads have dataValid = 0 and the fourth load has dataValid = 1. dataValid changes only at an edge where readyN falls.
- R9: byteOut shows dataOut bits 23..16 for byteSel = 2, bits 15..8 for byteSel = 1, bits 7..0 for byteSel = 0, and zero for byteSel = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resultValid | input | 1 | One-cycle strobe: a new raw result is present |
| resultRaw | input | 24 | Raw two's complement filter result |
| fmtOffset | input | 1 | 1 selects offset binary, 0 selects two's complement |
| unipolarEn | input | 1 | 1 clamps negative results to zero |
| chanSwitch | input | 1 | Pulse: the input multiplexer changed channel |
| readStart | input | 1 | Pulse: host begins reading |
| readEnd | input | 1 | Pulse: host has read the last byte |
| byteSel | input | 2 | Byte index for byteOut (2 = most significant) |
| dataOut | output | 24 | Output register contents |
| byteOut | output | 8 | Selected byte of dataOut |
| readyN | output | 1 | Active-low data-ready flag |
| dataValid | output | 1 | Loaded word is valid (not in the post-switch window) |

## Verification
The bench parks two results behind an open read. A design that forced the flag high, or loaded during the read, would change dataOut under the host or lose the later result.

It counts loads after a channel switch. An off-by-one window marks the fourth word invalid or the third one valid.

Negative inputs are run through the unipolar clamp in both formats. A clamp applied after formatting would report 0x000000 instead of 0x800000 in offset binary.

Back-to-back unread results check that the newer word replaces the older one. The out-of-range byte index must read as zero.

// File: rtl/crr_pkg.sv
package crr_pkg;
  typedef struct packed {
    logic capture;    // latch a formatted result into the pending slot
    logic commit;     // move the pending slot into the output register
    logic markValid;  // committed word is outside the post-switch window
  } crrStrobe_t;
endpackage

// File: rtl/crr_ctrl.sv
module crr_ctrl
  import crr_pkg::*;
#(
  parameter int SKIP = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       resultValid,
  input  logic       chanSwitch,
  input  logic       readStart,
  input  logic       readEnd,
  output crrStrobe_t strb,
  output logic       readyN
);
  localparam int CNTW = $clog2(SKIP + 1);

  logic            busy;
  logic            pendFull;
  logic [CNTW-1:0] skipLeft;

  // A load waits for a quiet cycle: no read open or starting or ending,
  // and no newer result arriving (that one replaces the pending word).
  always_comb begin
    strb.capture   = resultValid;
    strb.commit    = pendFull && !busy && !readStart && !readEnd && !resultValid;
    strb.markValid = strb.commit && (skipLeft == '0) && !chanSwitch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      pendFull <= 1'b0;
      readyN   <= 1'b1;
      skipLeft <= '0;
    end else begin
      if (readStart)    busy <= 1'b1;
      else if (readEnd) busy <= 1'b0;

      if (strb.capture)     pendFull <= 1'b1;
      else if (strb.commit) pendFull <= 1'b0;

      if (strb.capture && !busy && !readStart) readyN <= 1'b1;
      else if (readEnd)                        readyN <= 1'b1;
      else if (strb.commit)                    readyN <= 1'b0;

      if (chanSwitch)
        skipLeft <= CNTW'(SKIP);
      else if (strb.commit && skipLeft != '0)
        skipLeft <= skipLeft - CNTW'(1);
    end
  end
endmodule

// File: rtl/crr_datapath.sv
module crr_datapath
  import crr_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int BYTEW = 8,
  parameter int NBYTES = WIDTH / BYTEW,
  parameter int SELW = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  crrStrobe_t       strb,
  input  logic [WIDTH-1:0] resultRaw,
  input  logic             fmtOffset,
  input  logic             unipolarEn,
  input  logic [SELW-1:0]  byteSel,
  output logic [WIDTH-1:0] dataOut,
  output logic [BYTEW-1:0] byteOut,
  output logic             dataValid
);
  logic [WIDTH-1:0] pendWord;
  logic [WIDTH-1:0] fmtWord;
  logic [BYTEW-1:0] lanes [NBYTES];

  // Clamp first, then recode, so a clamped value reads as zero in either format.
  always_comb begin
    fmtWord = resultRaw;
    if (unipolarEn && resultRaw[WIDTH-1]) fmtWord = '0;
    if (fmtOffset) fmtWord[WIDTH-1] = ~fmtWord[WIDTH-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendWord  <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      if (strb.capture) pendWord <= fmtWord;
      if (strb.commit) begin
        dataOut   <= pendWord;
        dataValid <= strb.markValid;
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lanes[g] = dataOut[g*BYTEW +: BYTEW];
  end

  always_comb begin
    byteOut = '0;
    for (int i = 0; i < NBYTES; i++)
      if (byteSel == SELW'(i)) byteOut = lanes[i];
  end
endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg
  import crr_pkg::*;
#(
  parameter int WIDTH = 24,
  parameter int BYTEW = 8,
  parameter int SKIP = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             resultValid,
  input  logic [WIDTH-1:0]                 resultRaw,
  input  logic                             fmtOffset,
  input  logic                             unipolarEn,
  input  logic                             chanSwitch,
  input  logic                             readStart,
  input  logic                             readEnd,
  input  logic [$clog2(WIDTH/BYTEW)-1:0]   byteSel,
  output logic [WIDTH-1:0]                 dataOut,
  output logic [BYTEW-1:0]                 byteOut,
  output logic                             readyN,
  output logic                             dataValid
);
  localparam int NBYTES = WIDTH / BYTEW;
  localparam int SELW = $clog2(NBYTES);

  crrStrobe_t strb;

  crr_ctrl #(.SKIP(SKIP)) u_ctrl (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .chanSwitch(chanSwitch),
    .readStart(readStart), .readEnd(readEnd), .strb(strb), .readyN(readyN)
  );

  crr_datapath #(.WIDTH(WIDTH), .BYTEW(BYTEW), .NBYTES(NBYTES), .SELW(SELW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .resultRaw(resultRaw),
    .fmtOffset(fmtOffset), .unipolarEn(unipolarEn), .byteSel(byteSel),
    .dataOut(dataOut), .byteOut(byteOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/conv_result_reg_chk.sv
module conv_result_reg_chk #(
  parameter int WIDTH = 24,
  parameter int BYTEW = 8,
  parameter int SKIP = 3
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           chanSwitch,
  input logic                           readStart,
  input logic                           readEnd,
  input logic [$clog2(WIDTH/BYTEW)-1:0] byteSel,
  input logic [WIDTH-1:0]               dataOut,
  input logic [BYTEW-1:0]               byteOut,
  input logic                           readyN,
  input logic                           dataValid
);
  localparam int NBYTES = WIDTH / BYTEW;
  localparam int SELW = $clog2(NBYTES);
  localparam int CNTW = $clog2(SKIP + 1);

  logic            busyC;
  logic [CNTW-1:0] skipC;
  logic            readyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyC  <= 1'b0;
      skipC  <= '0;
      readyQ <= 1'b1;
    end else begin
      readyQ <= readyN;
      if (readStart)    busyC <= 1'b1;
      else if (readEnd) busyC <= 1'b0;
      if (chanSwitch)
        skipC <= CNTW'(SKIP);
      else if (readyQ && !readyN && skipC != '0)
        skipC <= skipC - CNTW'(1);
    end
  end

  // R2
  load_lowers_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> !readyN);

  // R3
  hold_during_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyC && $past(busyC)) |-> $stable(dataOut));

  // R4
  read_end_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    readEnd |=> readyN);

  // R8
  skip_invalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipC != '0 && $fell(readyN)) |-> !dataValid);

  // R8
  valid_with_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> $fell(readyN));

  // R9
  top_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteSel == SELW'(NBYTES - 1)) |-> (byteOut == dataOut[WIDTH-1 -: BYTEW]));
endmodule

bind conv_result_reg conv_result_reg_chk #(.WIDTH(WIDTH), .BYTEW(BYTEW), .SKIP(SKIP)) u_chk (.*);

// File: tb/test_conv_result_reg.sv
module test_conv_result_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [23:0] resultRaw = '0;
  logic        fmtOffset = 1'b0;
  logic        unipolarEn = 1'b0;
  logic        chanSwitch = 1'b0;
  logic        readStart = 1'b0;
  logic        readEnd = 1'b0;
  logic [1:0]  byteSel = '0;
  logic [23:0] dataOut;
  logic [7:0]  byteOut;
  logic        readyN;
  logic        dataValid;

  int checks = 0;
  int errors = 0;
  int skipModel = 0;
  bit done = 1'b0;
  logic [24:0] expQ[$];

  always #2 clk = ~clk;

  conv_result_reg i_conv_result_reg (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  function automatic logic [23:0] model(input logic [23:0] raw);
    logic [23:0] v;
    v = (unipolarEn && raw[23]) ? 24'h0 : raw;
    if (fmtOffset) v[23] = ~v[23];
    return v;
  endfunction

  // Driver: one-cycle strobe; optionally predicts the load it causes.
  task automatic sendResult(input logic [23:0] raw, input bit expectLoad);
    tick;
    resultRaw   = raw;
    resultValid = 1'b1;
    if (expectLoad) pushExp(model(raw));
    tick;
    resultValid = 1'b0;
  endtask

  task automatic pushExp(input logic [23:0] w);
    expQ.push_back({skipModel == 0, w});
    if (skipModel > 0) skipModel--;
  endtask

  // Monitor: each falling ready edge is one load; compare with the queue.
  initial begin
    logic prevReady;
    logic [24:0] e;
    prevReady = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN && prevReady && !readyN) begin
        if (expQ.size() == 0) begin
          check("R2 unexpected load", 32'(dataOut), 32'hffffffff);
        end else begin
          e = expQ.pop_front();
          check("R6/R7 loaded word", 32'(dataOut), 32'(e[23:0]));
          check("R8 valid flag", 32'(dataValid), 32'(e[24]));
        end
      end
      prevReady = readyN;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rstN = 1'b1;
    tick;
    // R1
    check("R1 readyN", 32'(readyN), 32'd1);
    check("R1 dataValid", 32'(dataValid), 32'd0);
    check("R1 dataOut", 32'(dataOut), 32'h0);

    // R2 sequencing and R6 two's complement
    sendResult(24'h123456, 1'b1);
    check("R2 ready high before load", 32'(readyN), 32'd1);
    check("R2 data not yet loaded", 32'(dataOut), 32'h0);
    tick;
    check("R2 ready low after load", 32'(readyN), 32'd0);
    check("R2 data loaded", 32'(dataOut), 32'h123456);

    // R9 byte access
    byteSel = 2'd2; #1 check("R9 byte2", 32'(byteOut), 32'h12);
    byteSel = 2'd1; #1 check("R9 byte1", 32'(byteOut), 32'h34);
    byteSel = 2'd0; #1 check("R9 byte0", 32'(byteOut), 32'h56);
    byteSel = 2'd3; #1 check("R9 out of range", 32'(byteOut), 32'h0);

    // R5 overwrite of unread results
    sendResult(24'hABCDEF, 1'b1);
    tick;
    sendResult(24'h00FF00, 1'b1);
    tick;
    check("R5 newest word kept", 32'(dataOut), 32'h00FF00);

    // R3 and R4: results during a read are held back
    tick; readStart = 1'b1;
    tick; readStart = 1'b0;
    sendResult(24'h111111, 1'b0);
    check("R3 ready stays low", 32'(readyN), 32'd0);
    tick;
    check("R3 data held", 32'(dataOut), 32'h00FF00);
    sendResult(24'h222222, 1'b0);
    repeat (2) tick;
    check("R3 data still held", 32'(dataOut), 32'h00FF00);
    pushExp(model(24'h222222));
    readEnd = 1'b1;
    tick; readEnd = 1'b0;
    check("R4 ready high after read end", 32'(readyN), 32'd1);
    tick;
    check("R3 parked word loaded", 32'(dataOut), 32'h222222);
    check("R3 ready low", 32'(readyN), 32'd0);

    // R6 offset binary
    fmtOffset = 1'b1;
    sendResult(24'h000010, 1'b1);
    tick;
    check("R6 offset positive", 32'(dataOut), 32'h800010);
    sendResult(24'hFFFFF0, 1'b1);
    tick;
    check("R6 offset negative", 32'(dataOut), 32'h7FFFF0);

    // R7 unipolar clamp in both formats
    unipolarEn = 1'b1;
    sendResult(24'h800001, 1'b1);
    tick;
    check("R7 clamp offset", 32'(dataOut), 32'h800000);
    fmtOffset = 1'b0;
    sendResult(24'hF00000, 1'b1);
    tick;
    check("R7 clamp twos", 32'(dataOut), 32'h000000);
    sendResult(24'h000123, 1'b1);
    tick;
    check("R7 positive passes", 32'(dataOut), 32'h000123);
    unipolarEn = 1'b0;

    // R8 channel switch window
    tick; chanSwitch = 1'b1; skipModel = 3;
    tick; chanSwitch = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sendResult(24'h000100 + 24'(k), 1'b1);
      tick;
      check("R8 window", 32'(dataValid), (k == 3) ? 32'd1 : 32'd0);
    end

    repeat (3) tick;
    check("R2 all predicted loads seen", 32'(expQ.size()), 32'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule